// File: doc/BRIEF.md
# Interlocked Forward-Transfer Host Engine

This block is the host-side sequencer for the forward direction of an extended-capability parallel port. It takes bytes one at a time from a local valid/ready stream and places each byte on an 8-bit output bus. It then moves the active-low host strobe through a fully interlocked exchange with the peripheral's busy/acknowledge line. Each strobe edge waits for a particular level of that line, which is sampled only after a two-flop synchronizer.

A byte leaves the engine in four steps. First the data is driven and held for a programmable number of setup cycles. Once the peripheral is no longer busy, the strobe falls. When the peripheral acknowledges by raising its line, the strobe rises. The transfer is finished when the peripheral lowers its line again, and the peripheral takes the byte at that moment.

The peripheral can raise its asynchronous reverse-request line at any time; the engine passes the synchronized request on as a flag. A timeout watches every waiting state. If the peripheral does not reach the expected level in time, the engine drops back to idle with the strobe high and raises an error flag.

States: `ST_IDLE` (ready for a byte), `ST_SETUP` (data driven, strobe high), `ST_STB_LO` (strobe low, waiting for acknowledge high), `ST_STB_HI` (strobe high again, waiting for acknowledge low). The transitions are:
- accept: `ST_IDLE` to `ST_SETUP`
- setup_done: `ST_SETUP` to `ST_STB_LO`
- acked: `ST_STB_LO` to `ST_STB_HI`
- complete: `ST_STB_HI` to `ST_IDLE`
- timeout: any waiting state to `ST_IDLE`

Top module: `fwd_host_engine`

## Requirements
- R1: `s_ready` is high exactly when the engine is idle. A byte is taken at a clock edge where `s_valid` and `s_ready` are both high, and it appears on `bus_data` in the next cycle.
- R2: `bus_data` does not change from the cycle after a byte is taken until the engine is idle again.
- R3: `host_strobe_n` falls no earlier than `SETUP_CYC` cycles (default 4) after the cycle in which `bus_data` takes a new byte.
- R4: `host_strobe_n` (1 = high, 0 = low) falls only at an edge where the synchronized acknowledge is low.
- R5: after falling, `host_strobe_n` rises at the edge where the synchronized acknowledge is seen high, or on timeout.
- R6: after the strobe rises, the engine returns to idle at the edge where the synchronized acknowledge is seen low, or on timeout.
- R7: the acknowledge and reverse-request inputs are each resynchronized through two flops. A change on either input affects the engine's decisions and outputs two clock edges later.
- R8: `rev_pending` is the inverse of the synchronized `periph_rev_req_n` (0 = request) at all times, including during transfers.
- R9: if a waiting state lasts `TIMEOUT_CYC` cycles (default 64) without its exit condition, the engine goes to idle with the strobe high and sets `xfer_err` to 1.
- R10: `xfer_err` stays set until the next byte is taken, and it clears at that edge.
- R11: while reset is asserted and just after it, `host_strobe_n`=1, `s_ready`=1, `xfer_err`=0, `bus_data`=0 and `rev_pending`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Local stream: byte offered |
| s_data | input | DATA_W | Local stream: byte value |
| s_ready | output | 1 | Local stream: engine idle, byte taken on valid |
| bus_data | output | DATA_W | Data bus to the peripheral |
| host_strobe_n | output | 1 | Host strobe, active low |
| periph_busy_ack | input | 1 | Peripheral busy/acknowledge line, asynchronous |
| periph_rev_req_n | input | 1 | Peripheral reverse-request line, active low, asynchronous |
| rev_pending | output | 1 | Synchronized reverse request |
| xfer_err | output | 1 | Handshake timeout flag |

## Verification
The assertions assume that `periph_busy_ack` changes level without glitches that are shorter than a clock. They also assume the stream holds `s_valid` until the byte is taken. The bench drives all inputs at the falling clock edge. Its peripheral model moves the acknowledge line only in response to the strobe, after a random delay of up to three cycles. Outside that model, the line is held stuck at one level on purpose so that each waiting state reaches its timeout.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STB_LO = 2'd2,
        ST_STB_HI = 2'd3
    } fwd_state_t;
endpackage

// File: rtl/fwd_sync.sv
module fwd_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
                else        chain <= {chain[STAGES-2:0], async_in[g]};
            end
            assign sync_out[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/fwd_timer.sv
module fwd_timer #(
    parameter int SETUP_CYC   = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic setup_done,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] TO_LAST    = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (clear)        cnt <= '0;
        else if (cnt != TO_LAST) cnt <= cnt + 1'b1;
    end

    assign setup_done = (cnt >= SETUP_LAST);
    assign expired    = (cnt == TO_LAST);
endmodule

// File: rtl/fwd_host_engine.sv
module fwd_host_engine
    import fwd_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SETUP_CYC   = 4,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic [DATA_W-1:0] bus_data,
    output logic              host_strobe_n,
    input  logic              periph_busy_ack,
    input  logic              periph_rev_req_n,
    output logic              rev_pending,
    output logic              xfer_err
);
    fwd_state_t        state, nxt;
    logic [DATA_W-1:0] hold_q;
    logic              err_q;
    logic              ack_s, req_n_s;
    logic              setup_done, expired, timer_clr;
    logic              take, timeout;
    logic [1:0]        sync_o;

    fwd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({periph_rev_req_n, periph_busy_ack}),
        .sync_out (sync_o)
    );
    assign ack_s   = sync_o[0];
    assign req_n_s = sync_o[1];

    fwd_timer #(.SETUP_CYC(SETUP_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (timer_clr),
        .setup_done (setup_done),
        .expired    (expired)
    );

    // next-state logic
    always_comb begin
        nxt     = state;
        timeout = 1'b0;
        unique case (state)
            ST_IDLE:   if (s_valid) nxt = ST_SETUP;
            ST_SETUP: begin
                if (setup_done && !ack_s) nxt = ST_STB_LO;
                else if (expired) begin nxt = ST_IDLE; timeout = 1'b1; end
            end
            ST_STB_LO: begin
                if (ack_s) nxt = ST_STB_HI;
                else if (expired) begin nxt = ST_IDLE; timeout = 1'b1; end
            end
            ST_STB_HI: begin
                if (!ack_s) nxt = ST_IDLE;
                else if (expired) begin nxt = ST_IDLE; timeout = 1'b1; end
            end
            default:   nxt = ST_IDLE;
        endcase
    end

    assign take      = (state == ST_IDLE) && s_valid;
    assign timer_clr = (state == ST_IDLE) || (nxt != state);

    // state register and held data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            hold_q <= '0;
            err_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (take) begin
                hold_q <= s_data;
                err_q  <= 1'b0;
            end else if (timeout) begin
                err_q  <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        s_ready       = (state == ST_IDLE);
        host_strobe_n = (state != ST_STB_LO);
        bus_data      = hold_q;
        xfer_err      = err_q;
        rev_pending   = !req_n_s;
    end

    // R4: strobe falls only after synchronized acknowledge was low
    a_r4_fall_on_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_strobe_n) |-> !$past(ack_s));

    // R5: strobe rises on acknowledge high or by timeout
    a_r5_rise_on_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_strobe_n) |-> ($past(ack_s) || xfer_err));

    // R6: back to idle only on acknowledge low or by timeout
    a_r6_done_on_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_ready) |-> (!$past(ack_s) || xfer_err));

    // R2: the bus is frozen while a transfer is in flight
    a_r2_bus_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s_ready) |-> $stable(bus_data));

    // R1: ready never coincides with a low strobe
    a_r1_ready_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> host_strobe_n);

    // R9: a raised error flag means the engine went idle
    a_r9_err_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_err) |-> (s_ready && host_strobe_n));

    // R10: error clears only when a byte is taken
    a_r10_err_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_err) |-> ($past(s_valid) && $past(s_ready)));
endmodule

// File: tb/tb_fwd_host_engine.sv
module tb_fwd_host_engine;
    localparam int SETUP = 4;
    localparam int TO    = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_ready;
    logic [7:0] bus_data;
    logic       host_strobe_n;
    logic       periph_busy_ack = 1'b0;
    logic       periph_rev_req_n = 1'b1;
    logic       rev_pending;
    logic       xfer_err;

    fwd_host_engine dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .bus_data(bus_data), .host_strobe_n(host_strobe_n),
        .periph_busy_ack(periph_busy_ack), .periph_rev_req_n(periph_rev_req_n),
        .rev_pending(rev_pending), .xfer_err(xfer_err)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;

    // reference model state
    int m_phase = 0;
    int m_cnt   = 0;
    int m_hold  = 0;
    int m_err   = 0;
    int m_ack1 = 1, m_ack2 = 1, m_req1 = 1, m_req2 = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_hold = 0; m_err = 0;
            m_ack1 = 1; m_ack2 = 1; m_req1 = 1; m_req2 = 1;
        end else begin
            case (m_phase)
                0: if (s_valid) begin m_hold = s_data; m_err = 0; m_phase = 1; m_cnt = 0; end
                1: if (m_cnt >= SETUP - 1 && m_ack2 == 0) begin m_phase = 2; m_cnt = 0; end
                   else if (m_cnt == TO - 1) begin m_phase = 0; m_cnt = 0; m_err = 1; end
                   else m_cnt++;
                2: if (m_ack2 == 1) begin m_phase = 3; m_cnt = 0; end
                   else if (m_cnt == TO - 1) begin m_phase = 0; m_cnt = 0; m_err = 1; end
                   else m_cnt++;
                default: if (m_ack2 == 0) begin m_phase = 0; m_cnt = 0; end
                   else if (m_cnt == TO - 1) begin m_phase = 0; m_cnt = 0; m_err = 1; end
                   else m_cnt++;
            endcase
            m_ack2 = m_ack1; m_ack1 = periph_busy_ack;
            m_req2 = m_req1; m_req1 = periph_rev_req_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        if (act != exp) begin
            misses++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
        end
    endtask

    // peripheral model and stream driver
    int       mode = 0;     // 0 normal, 1 stuck busy, 2 never ack, 3 ack stuck high
    int       lat = 1, wcnt = 0;
    bit       pend = 0;
    logic [7:0] q[$];

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            vectors++;
            chk("R1/R6 s_ready", s_ready, m_phase == 0);
            chk("R2 bus_data", bus_data, m_hold);
            chk("R3/R4/R5 host_strobe_n", host_strobe_n, m_phase != 2);
            chk("R7/R8 rev_pending", rev_pending, m_req2 == 0);
            chk("R9/R10 xfer_err", xfer_err, m_err);
        end
        case (mode)
            1: periph_busy_ack = 1'b1;
            2: periph_busy_ack = 1'b0;
            3: if (!host_strobe_n) periph_busy_ack = 1'b1;
            default: begin
                if (periph_busy_ack != !host_strobe_n) begin
                    if (wcnt >= lat) begin
                        periph_busy_ack = !host_strobe_n;
                        wcnt = 0;
                        lat = $urandom_range(0, 3);
                    end else wcnt++;
                end
            end
        endcase
        if ($urandom_range(0, 7) == 0) periph_rev_req_n = ~periph_rev_req_n;
        if (pend) begin s_valid = 1'b0; pend = 0; end
        if (!s_valid && q.size() > 0 && $urandom_range(0, 1) == 1) begin
            s_valid = 1'b1; s_data = q.pop_front();
        end else if (!s_valid) s_data = 8'($urandom);
        pend = s_valid && s_ready;
        if (cycles > 20000) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic drain();
        while (q.size() > 0 || s_valid || !s_ready) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values while reset is held
        vectors++; chk("R11 strobe", host_strobe_n, 1);
        vectors++; chk("R11 ready", s_ready, 1);
        vectors++; chk("R11 err", xfer_err, 0);
        vectors++; chk("R11 bus", bus_data, 0);
        vectors++; chk("R11 rev", rev_pending, 0);
        rst_n = 1'b1;
        // normal traffic with varied values (R1..R8)
        q.push_back(8'hA5); q.push_back(8'h00); q.push_back(8'hFF); q.push_back(8'h3C);
        for (int i = 0; i < 40; i++) q.push_back(8'($urandom));
        drain();
        // R9: timeout in setup (peripheral stuck busy)
        mode = 1; q.push_back(8'h11); drain();
        vectors++; chk("R9 err after setup timeout", xfer_err, 1);
        // R10: next byte clears the flag
        mode = 0; repeat (6) @(negedge clk);
        q.push_back(8'h22); drain();
        vectors++; chk("R10 err cleared", xfer_err, 0);
        // R9: timeout with strobe low
        mode = 2; q.push_back(8'h33); drain();
        vectors++; chk("R9 err after strobe-low timeout", xfer_err, 1);
        // R9: timeout with strobe high again
        mode = 3; q.push_back(8'h44); drain();
        vectors++; chk("R9 err after strobe-high timeout", xfer_err, 1);
        mode = 0; repeat (8) @(negedge clk);
        for (int i = 0; i < 20; i++) q.push_back(8'($urandom));
        drain();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule